// File: doc/BRIEF.md
# Subclock Interval Timer with Interrupt

This block measures fixed intervals on a slow subclock. A free-running 16-bit prescaler advances once on each clock cycle in which the subclock tick enable is high. A 2-bit select field picks one of four prescaler bits as the interval tap. When the chosen bit falls from 1 to 0, an interval flag is latched. The flag is latched whatever the interrupt enable holds. An interrupt request goes to the processor whenever both the flag and the enable are 1.

Software uses one 5-bit control register with a write strobe and read-back. The register holds the tap select, the enable and the flag. Software clears the flag by writing 0 to it. The register also carries a self-restoring active-low counter clear.

Two conditions stop the flag from latching. A stop-mode input blocks it, and so does a counter clear that lands in the same cycle as the tap's falling edge.

The flag is held by a two-state machine:
- FLAG_IDLE moves to FLAG_PEND on a qualified set event.
- FLAG_PEND moves back to FLAG_IDLE on a software clear, unless a set event arrives in that same cycle.
- In every other case the state holds.

Top module: `subclk_interval_timer`

## Requirements
- R1: The 16-bit prescaler adds one at each rising clock edge where tick_i is 1, and holds its value when tick_i is 0.
- R2: Register bits [4:3] select the tap: 0 picks prescaler bit 9, 1 picks bit 12, 2 picks bit 14 and 3 picks bit 15. After a counter clear, the flag (register bit 0) becomes 1 at the edge of the 2^(b+1)-th tick, where b is the selected bit, and stays 0 before it.
- R3: The flag is set whatever the enable (register bit 1) holds. irq_o stays 0 while the enable is 0.
- R4: irq_o is 1 exactly when the flag and the enable are both 1. If software enables while the flag is pending, irq_o is 1 right after that write edge.
- R5: A write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag unchanged and never sets it.
- R6: A write with bit 2 = 0 zeroes the prescaler at that edge, taking priority over a tick in the same cycle. Bit 2 returns to 1 by itself and always reads as 1.
- R7: A counter clear in the same cycle as the selected tap's falling edge keeps the flag from being set.
- R8: While stop_i is 1, a falling edge of the tap does not set the flag.
- R9: A software flag clear in the same cycle as a set event leaves the flag at 1.
- R10: After reset the prescaler, flag, enable and select are 0. rd_data_o reads 5'b00100 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Subclock tick enable, one prescaler step per high cycle |
| stop_i | input | 1 | Stop-mode indication; blocks flag setting |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 5 | Write data: [0] flag, [1] enable, [2] clear_n, [4:3] select |
| rd_data_o | output | 5 | Register read-back in the same layout |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Each register write and each tick takes effect at the rising edge where it is presented. Every result therefore shows on rd_data_o and irq_o directly after that edge, with zero added latency: this covers the prescaler step, the flag set on the last tick of an interval, a flag clear, and the request after an enable write. The bench drives inputs on the falling edge and samples one time unit after the rising edge. It counts ticks itself from the last counter clear and checks the flag both one tick before and exactly on the interval boundary. Coincidence cases (clear with a falling edge, software clear with a set event, stop with a falling edge) are presented in the single cycle of the boundary tick.

// File: rtl/sit_pkg.sv
package sit_pkg;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_st_e;

    localparam int unsigned FLD_FLAG   = 0;
    localparam int unsigned FLD_EN     = 1;
    localparam int unsigned FLD_CLRN   = 2;
    localparam int unsigned FLD_SEL_LO = 3;

endpackage

// File: rtl/sit_prescaler.sv
module sit_prescaler #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_nxt_o = cnt_q + {{(CNT_W-1){1'b0}}, tick_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt_o;
        end
    end

    assign cnt_o = cnt_q;

    // R1: a tick without clear advances by exactly one
    a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1: no tick and no clear holds the value
    a_r1_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

    // R6: clear wins over a tick
    a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/sit_tap_edge.sv
module sit_tap_edge #(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned NUM_TAPS = 4,
    parameter int unsigned TAP_POS [NUM_TAPS] = '{9, 12, 14, 15}
) (
    input  logic [CNT_W-1:0] cnt_cur_i,
    input  logic [CNT_W-1:0] cnt_nxt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             fall_o
);

    logic [NUM_TAPS-1:0] tap_cur;
    logic [NUM_TAPS-1:0] tap_nxt;

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_cur[i] = cnt_cur_i[TAP_POS[i]];
        assign tap_nxt[i] = cnt_nxt_i[TAP_POS[i]];
    end

    // Both samples use the same select, so a select change is never an edge.
    always_comb begin
        fall_o = tap_cur[sel_i] & ~tap_nxt[sel_i];
    end

endmodule

// File: rtl/sit_flag_fsm.sv
module sit_flag_fsm
    import sit_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic swclr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);

    flag_st_e state_q;
    flag_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (set_i) begin
                    state_d = FLAG_PEND;
                end
            end
            FLAG_PEND: begin
                if (swclr_i && !set_i) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        flag_o = (state_q == FLAG_PEND);
        irq_o  = (state_q == FLAG_PEND) && en_i;
    end

    // R9: a set event always leaves the flag pending
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> flag_o);

    // R3: disabled means no request
    a_r3_no_irq_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !irq_o);

    // R5: only a clear strobe can drop the flag
    a_r5_flag_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag_o) |-> $past(swclr_i));

endmodule

// File: rtl/subclk_interval_timer.sv
module subclk_interval_timer
    import sit_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned TAP_POS [2**SEL_W] = '{9, 12, 14, 15}
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 stop_i,
    input  logic                 wr_en_i,
    input  logic [SEL_W+2:0]     wr_data_i,
    output logic [SEL_W+2:0]     rd_data_o,
    output logic                 irq_o
);

    localparam int unsigned NUM_TAPS = 2**SEL_W;

    logic [SEL_W-1:0] sel_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             fall;
    logic             clr_req;
    logic             swclr;
    logic             set_ev;
    logic             flag;

    always_comb begin
        clr_req = wr_en_i && !wr_data_i[FLD_CLRN];
        swclr   = wr_en_i && !wr_data_i[FLD_FLAG];
        set_ev  = fall && !clr_req && !stop_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else if (wr_en_i) begin
            sel_q <= wr_data_i[FLD_SEL_LO +: SEL_W];
            en_q  <= wr_data_i[FLD_EN];
        end
    end

    sit_prescaler #(
        .CNT_W (CNT_W)
    ) u_prescaler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .clr_i     (clr_req),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt)
    );

    sit_tap_edge #(
        .CNT_W    (CNT_W),
        .SEL_W    (SEL_W),
        .NUM_TAPS (NUM_TAPS),
        .TAP_POS  (TAP_POS)
    ) u_tap_edge (
        .cnt_cur_i (cnt),
        .cnt_nxt_i (cnt_nxt),
        .sel_i     (sel_q),
        .fall_o    (fall)
    );

    sit_flag_fsm u_flag_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (set_ev),
        .swclr_i (swclr),
        .en_i    (en_q),
        .flag_o  (flag),
        .irq_o   (irq_o)
    );

    assign rd_data_o = {sel_q, 1'b1, en_q, flag};

    // R8: stop mode keeps the flag from rising
    a_r8_stop_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !$rose(flag));

    // R7: a counter clear keeps the flag from rising
    a_r7_clear_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_req |=> !$rose(flag));

    // R4: enabling with a pending flag requests at once
    a_r4_pending_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(en_q) && flag) |-> irq_o);

    // R2: a tap edge only comes from a tick
    a_r2_fall_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall |-> tick_i);

endmodule

// File: tb/subclk_interval_timer_bench.sv
module subclk_interval_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [4:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    subclk_interval_timer u_subclk_interval_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .tick_i    (tick),
        .stop_i    (stop),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    // vectors: select code, ticks from clear to flag set
    localparam int VEC [4][2] = '{'{0, 1024}, '{1, 8192}, '{2, 32768}, '{3, 65536}};

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog act %0d exp below 190000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [4:0] d);
        @(negedge clk);
        tick    = t;
        wr_en   = w;
        wr_data = d;
        @(posedge clk);
        #1;
        tick  = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 5'b0);
    endtask

    // layout {sel[1:0], clear_n, enable, flag}
    function automatic logic [4:0] rw(input int sel, input bit clrn, input bit en, input bit fl);
        return {sel[1:0], clrn, en, fl};
    endfunction

    initial begin
        #22;
        check("R10 reset readback", int'(rd_data), 4);
        check("R10 reset irq", int'(irq), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 4; v++) begin
            cyc(1'b0, 1'b1, rw(VEC[v][0], 0, 0, 0));
            ticks(VEC[v][1] - 1);
            check($sformatf("R2 sel %0d before boundary", VEC[v][0]), int'(rd_data[0]), 0);
            ticks(1);
            check($sformatf("R2 sel %0d on boundary", VEC[v][0]), int'(rd_data[0]), 1);
            check($sformatf("R3 flag set with enable 0, irq low, sel %0d", VEC[v][0]), int'(irq), 0);
        end

        // R1: idle cycles do not advance the prescaler
        cyc(1'b0, 1'b1, rw(0, 0, 0, 0));
        ticks(1000);
        for (int i = 0; i < 50; i++) cyc(1'b0, 1'b0, 5'b0);
        ticks(23);
        check("R1 hold without tick", int'(rd_data[0]), 0);
        ticks(1);
        check("R1 count resumes", int'(rd_data[0]), 1);

        // R7 and R6: clear on the boundary tick
        cyc(1'b0, 1'b1, rw(0, 0, 0, 0));
        ticks(1023);
        cyc(1'b1, 1'b1, rw(0, 0, 0, 1));
        check("R7 clear with edge suppresses flag", int'(rd_data[0]), 0);
        check("R6 clear_n reads 1", int'(rd_data[2]), 1);
        ticks(1023);
        check("R6 counter restarted from zero", int'(rd_data[0]), 0);
        ticks(1);
        check("R6 interval after clear", int'(rd_data[0]), 1);

        // R9: software clear during a set event
        cyc(1'b0, 1'b1, rw(0, 0, 0, 0));
        ticks(1023);
        cyc(1'b1, 1'b1, rw(0, 1, 0, 0));
        check("R9 set wins over clear", int'(rd_data[0]), 1);

        // R5: clear by 0, write of 1 no effect
        cyc(1'b0, 1'b1, rw(0, 1, 0, 0));
        check("R5 write 0 clears flag", int'(rd_data[0]), 0);
        cyc(1'b0, 1'b1, rw(0, 1, 0, 1));
        check("R5 write 1 does not set flag", int'(rd_data[0]), 0);

        // R4: enable with a pending flag
        cyc(1'b0, 1'b1, rw(0, 0, 0, 0));
        ticks(1024);
        check("R4 flag pending, disabled irq", int'(irq), 0);
        cyc(1'b0, 1'b1, rw(0, 1, 1, 1));
        check("R4 irq on enable with pending flag", int'(irq), 1);
        check("R4 enable reads back", int'(rd_data[1]), 1);
        cyc(1'b0, 1'b1, rw(0, 1, 1, 0));
        check("R4 irq drops after flag clear", int'(irq), 0);

        // R8: stop mode across the boundary
        cyc(1'b0, 1'b1, rw(0, 0, 1, 0));
        ticks(1023);
        stop = 1'b1;
        ticks(1);
        stop = 1'b0;
        check("R8 stop blocks flag", int'(rd_data[0]), 0);
        check("R8 stop no irq", int'(irq), 0);
        ticks(1024);
        check("R8 next interval sets after stop ends", int'(irq), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule